// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a small bank of eight byte-wide configuration registers. It watches SCL and SDA through a fast system clock, decodes start and stop conditions, and answers its own seven-bit address. The SDA pin is modelled as open drain: the block only ever pulls the line low, through an output enable.

Bit 7 of the command byte chooses the access kind. When it is 1, a single register is reached, and its offset sits in the low seven bits. When it is 0, the access is a block transfer. A block transfer always begins at offset 0 and carries a byte count ahead of the data. The block write ignores the count that the host sends. The block read sends a count of 8 before the data. Offsets 1 to 6 are plain storage. Offset 0 mixes four stored bits with four live status bits: two latched straps, a CPU-stop pin, and the combined PCI-stop state. Offset 7 is a fixed identification value. The stored bits are brought out flat so that the rest of the clock logic can decode them.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the stored registers hold offset0 = 0x40, offset1 = 0x7F, offset2 = 0x00, offset3 = 0xFF, offset4 = 0x47, offset5 = 0xDF and offset6 = 0x03, and SDA is not driven.
- R2: The slave acknowledges only the address 7'b1101001, which is byte 0xD2 for a write and 0xD3 for a read. Traffic to any other address gets no acknowledge and changes nothing.
- R3: A byte write (start, 0xD2, command {1, offset[6:0]}, data, stop) stores the data at that offset, and the slave acknowledges every byte it receives.
- R4: A byte read (start, 0xD2, command {1, offset}, repeated start, 0xD3, one byte, master NACK, stop) returns the register at that offset, most significant bit first.
- R5: A block write (command 0x00, then a count byte, then data) stores the data bytes at offsets 0, 1, 2 and so on upward, whatever the count says. A stop after any complete byte keeps the bytes written so far.
- R6: A block read (command 0x00, repeated start, 0xD3) returns the count 0x08 first and then the registers from offset 0 upward, until the master NACKs.
- R7: Reads of offset 0 return stored bits [7:4], then bit 3 = PCI-stop pin AND offset3 bit 7, bit 2 = CPU-stop pin, and bits [1:0] = strap_i[1:0].
- R8: Offset 7 always reads 0x48 and ignores writes. Writes to offset 0 change only bits [7:4].
- R9: Writes to offsets 8 to 127 have no effect, and reads of those offsets return 0x00.
- R10: The slave pulls SDA low only during its acknowledge slots and its read data. The pull starts only while SCL is low, and a stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cpu_stop_n_i | input | 1 | CPU-stop pin level, read back in offset 0 bit 2 |
| pci_stop_n_i | input | 1 | PCI-stop pin level, combined into offset 0 bit 3 |
| strap_i | input | 2 | Latched frequency straps, read back in offset 0 bits [1:0] |
| cfg_o | output | 56 | Stored offsets 0..6, offset n at bits [8n+7:8n]; offset 0 bits [3:0] read 0 |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for start and stop conditions. They also assume that each SCL level lasts well beyond the two-flop synchronizer delay, so that edges and start/stop events seen inside the block keep their order. The bench drives SCL with quarter phases of five system clocks and moves SDA only in the middle of SCL low, so the input stays within those limits. The status pins and straps change only between transactions. This keeps a read of offset 0 stable while its byte is being shifted out.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RXACK,
        ST_RDATA,
        ST_TXACK
    } smb_state_e;

    // writable bits of offset 0; the low nibble is live status
    localparam logic [7:0] OFF0_WMASK = 8'hF0;

    // offset whose bit 7 is the software PCI-stop control
    localparam int SW_STOP_OFF = 3;
    localparam int SW_STOP_BIT = 7;

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'h7F;
            2:       return 8'h00;
            3:       return 8'hFF;
            4:       return 8'h47;
            5:       return 8'hDF;
            6:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe_d, scl_pipe_q;
    logic [PIPE_W-1:0] sda_pipe_d, sda_pipe_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe_q[STAGES-1];
    assign scl_prev = scl_pipe_q[STAGES];
    assign sda_now  = sda_pipe_q[STAGES-1];
    assign sda_prev = sda_pipe_q[STAGES];

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [7:0] ID_VALUE = 8'h48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [6:0]                    wr_addr_i,
    input  logic [7:0]                    wr_data_i,
    input  logic [6:0]                    rd_addr_i,
    output logic [7:0]                    rd_data_o,
    input  logic                          cpu_stop_n_i,
    input  logic                          pci_stop_n_i,
    input  logic [1:0]                    strap_i,
    output logic [(NUM_REGS-1)*BYTE_W-1:0] cfg_o
);
    localparam int         NUM_RW   = NUM_REGS - 1;
    localparam int         IDX_W    = $clog2(NUM_REGS);
    localparam logic [6:0] NUM_RW_A = 7'(NUM_RW);
    localparam logic [6:0] ID_OFF_A = 7'(NUM_REGS - 1);

    logic [7:0] mem_d [NUM_RW];
    logic [7:0] mem_q [NUM_RW];

    always_comb begin
        for (int i = 0; i < NUM_RW; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en_i && (wr_addr_i == 7'(i))) begin
                if (i == 0) begin
                    mem_d[i] = (wr_data_i & OFF0_WMASK) | (mem_q[i] & ~OFF0_WMASK);
                end else begin
                    mem_d[i] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RW; i++) begin
                mem_q[i] <= reg_reset(i);
            end
        end else begin
            for (int i = 0; i < NUM_RW; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_out
            assign cfg_o[g*BYTE_W +: BYTE_W] = mem_q[g];
        end
    endgenerate

    logic pci_stopped_n;
    assign pci_stopped_n = pci_stop_n_i & mem_q[SW_STOP_OFF][SW_STOP_BIT];

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == 7'd0) begin
            rd_data_o = {mem_q[0][7:4], pci_stopped_n, cpu_stop_n_i, strap_i};
        end else if (rd_addr_i < NUM_RW_A) begin
            rd_data_o = mem_q[rd_addr_i[IDX_W-1:0]];
        end else if (rd_addr_i == ID_OFF_A) begin
            rd_data_o = ID_VALUE;
        end
    end

endmodule

// File: rtl/smb_cfg_fsm.sv
module smb_cfg_fsm
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] BLOCK_COUNT = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    output logic       sda_oe_o,
    output logic       drive_ok_o,
    output logic       wr_en_o,
    output logic [6:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [6:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    typedef struct packed {
        smb_state_e state;
        smb_state_e nxt;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic       rw;
        logic       byte_mode;
        logic [6:0] ptr;
        logic       cnt_phase;
        logic       rd_first;
        logic       ack_on;
        logic       more;
        logic       sda_oe;
    } fsm_t;

    fsm_t d, q;

    logic [7:0] rx_byte;
    logic [7:0] tx_val;
    logic [6:0] tx_ptr;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = 8'h00;
        rx_byte   = {q.shreg[6:0], sda_s_i};
        tx_val    = q.rd_first ? BLOCK_COUNT : rd_data_i;
        tx_ptr    = q.rd_first ? q.ptr : q.ptr + 7'd1;

        if (stop_i) begin
            d.state  = ST_IDLE;
            d.sda_oe = 1'b0;
        end else if (start_i) begin
            d.state  = ST_ADDR;
            d.bitcnt = 4'd0;
            d.sda_oe = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise_i) begin
                        d.shreg  = rx_byte;
                        d.bitcnt = q.bitcnt + 4'd1;
                        if (q.bitcnt == 4'd7) begin
                            d.bitcnt = 4'd0;
                            d.ack_on = 1'b0;
                            d.state  = ST_RXACK;
                            if (q.state == ST_ADDR) begin
                                if (rx_byte[7:1] == DEV_ADDR) begin
                                    d.rw  = rx_byte[0];
                                    d.nxt = rx_byte[0] ? ST_RDATA : ST_CMD;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end else if (q.state == ST_CMD) begin
                                d.byte_mode = rx_byte[7];
                                d.ptr       = rx_byte[7] ? rx_byte[6:0] : 7'd0;
                                d.cnt_phase = ~rx_byte[7];
                                d.rd_first  = ~rx_byte[7];
                                d.nxt       = ST_WDATA;
                            end else begin
                                d.nxt = ST_WDATA;
                                if (q.cnt_phase) begin
                                    d.cnt_phase = 1'b0;
                                end else begin
                                    wr_en_o   = 1'b1;
                                    wr_data_o = rx_byte;
                                    d.ptr     = q.ptr + 7'd1;
                                end
                            end
                        end
                    end
                end
                ST_RXACK: begin
                    if (scl_fall_i) begin
                        if (!q.ack_on) begin
                            d.ack_on = 1'b1;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.ack_on = 1'b0;
                            d.state  = q.nxt;
                            if (q.nxt == ST_RDATA) begin
                                d.shreg    = tx_val;
                                d.sda_oe   = ~tx_val[7];
                                d.ptr      = tx_ptr;
                                d.rd_first = 1'b0;
                                d.bitcnt   = 4'd0;
                            end else begin
                                d.sda_oe = 1'b0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise_i) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i) begin
                        if (q.bitcnt == 4'd8) begin
                            d.sda_oe = 1'b0;
                            d.bitcnt = 4'd0;
                            d.more   = 1'b0;
                            d.state  = ST_TXACK;
                        end else begin
                            d.shreg  = {q.shreg[6:0], 1'b0};
                            d.sda_oe = ~q.shreg[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise_i) begin
                        if (sda_s_i) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.more = 1'b1;
                        end
                    end else if (scl_fall_i && q.more) begin
                        d.more     = 1'b0;
                        d.shreg    = tx_val;
                        d.sda_oe   = ~tx_val[7];
                        d.ptr      = tx_ptr;
                        d.rd_first = 1'b0;
                        d.bitcnt   = 4'd0;
                        d.state    = ST_RDATA;
                    end
                end
                default: begin
                    d.sda_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, nxt: ST_IDLE, bitcnt: 4'd0, shreg: 8'h00,
                   rw: 1'b0, byte_mode: 1'b0, ptr: 7'd0, cnt_phase: 1'b0,
                   rd_first: 1'b0, ack_on: 1'b0, more: 1'b0, sda_oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.sda_oe;
    assign rd_addr_o  = q.ptr;
    assign drive_ok_o = (q.state == ST_RXACK) || (q.state == ST_RDATA);

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] ID_VALUE    = 8'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    input  logic                          cpu_stop_n_i,
    input  logic                          pci_stop_n_i,
    input  logic [1:0]                    strap_i,
    output logic [(NUM_REGS-1)*BYTE_W-1:0] cfg_o
);
    localparam logic [7:0] BLOCK_COUNT = 8'(NUM_REGS);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_en, drive_ok;
    logic [6:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    smb_cfg_fsm #(.DEV_ADDR(DEV_ADDR), .BLOCK_COUNT(BLOCK_COUNT)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_evt),
        .stop_i     (stop_evt),
        .sda_oe_o   (sda_oe_o),
        .drive_ok_o (drive_ok),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data)
    );

    smb_cfg_regfile #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .cpu_stop_n_i (cpu_stop_n_i),
        .pci_stop_n_i (pci_stop_n_i),
        .strap_i      (strap_i),
        .cfg_o        (cfg_o)
    );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
    parameter int NUM_REGS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         scl_s,
    input logic                         stop_evt,
    input logic                         sda_oe,
    input logic                         drive_ok,
    input logic                         wr_en,
    input logic [6:0]                   wr_addr,
    input logic [7:0]                   wr_data,
    input logic [(NUM_REGS-1)*8-1:0]    cfg
);
    localparam logic [6:0] NUM_RW_A = 7'(NUM_REGS - 1);

    logic       last_wr_q;
    logic [6:0] last_addr_q;
    logic [7:0] last_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr_q   <= 1'b0;
            last_addr_q <= 7'd0;
            last_data_q <= 8'h00;
        end else begin
            last_wr_q   <= wr_en;
            last_addr_q <= wr_addr;
            last_data_q <= wr_data;
        end
    end

    logic [7:0] cfg_at_last;
    always_comb begin
        cfg_at_last = 8'h00;
        for (int i = 0; i < NUM_REGS - 1; i++) begin
            if (last_addr_q == 7'(i)) cfg_at_last = cfg[i*8 +: 8];
        end
    end

    // R10: the pull-down starts only while SCL is low
    a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R10: the pull-down only in acknowledge or read-data slots
    a_r10_oe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> drive_ok);

    // R10: a stop releases SDA
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R3: a write to a plain register lands in full
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (last_wr_q && last_addr_q != 7'd0 && last_addr_q < NUM_RW_A)
            |-> cfg_at_last == last_data_q);

    // R8: offset 0 takes only its upper nibble
    a_r8_low_nibble_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (last_wr_q && last_addr_q == 7'd0) |-> cfg[7:0] == {last_data_q[7:4], 4'h0});

    // R8, R9: writes to the identification offset or beyond change nothing
    a_r9_high_offset_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= NUM_RW_A) |=> $stable(cfg));

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe_o),
    .drive_ok (drive_ok),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg      (cfg_o)
);

// File: tb/smb_cfg_slave_tb.sv
`timescale 1ns/1ps
module smb_cfg_slave_tb_top;
    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        cpu_n = 1'b1;
    logic        pci_n = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic [55:0] cfg;
    logic        sda_line;

    assign sda_line = ~(m_low | sda_oe);

    always #10 clk = ~clk;

    smb_cfg_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .cpu_stop_n_i (cpu_n),
        .pci_stop_n_i (pci_n),
        .strap_i      (strap),
        .cfg_o        (cfg)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] mdl [0:6];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input int off);
        if (off == 0) return {mdl[0][7:4], pci_n & mdl[3][7], cpu_n, strap};
        if (off < 7)  return mdl[off];
        if (off == 7) return 8'h48;
        return 8'h00;
    endfunction

    function automatic logic [55:0] exp_cfg();
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    function automatic void mdl_write(input int off, input logic [7:0] v);
        if (off == 0) mdl[0] = {v[7:4], 4'h0};
        else if (off < 7) mdl[off] = v;
    endfunction

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            scl = 1'b1;    tick(2*Q);
            scl = 1'b0;    tick(Q);
        end
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        nak = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl = 1'b0; tick(Q);
        end
        m_low = ~last; tick(Q);
        scl = 1'b1;    tick(2*Q);
        scl = 1'b0;    tick(Q);
        m_low = 1'b0;
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] v, output logic nak_any);
        logic n;
        nak_any = 0;
        bus_start();
        send_byte(8'hD2, n); nak_any |= n;
        send_byte({1'b1, off}, n); nak_any |= n;
        send_byte(v, n); nak_any |= n;
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] v, output logic nak_any);
        logic n;
        nak_any = 0;
        bus_start();
        send_byte(8'hD2, n); nak_any |= n;
        send_byte({1'b1, off}, n); nak_any |= n;
        bus_start();
        send_byte(8'hD3, n); nak_any |= n;
        recv_byte(1'b1, v);
        bus_stop();
    endtask

    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:8];

    task automatic block_write(input int n, output logic nak_any);
        logic k;
        nak_any = 0;
        bus_start();
        send_byte(8'hD2, k); nak_any |= k;
        send_byte(8'h00, k); nak_any |= k;
        send_byte(8'(n), k); nak_any |= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); nak_any |= k;
        end
        bus_stop();
    endtask

    task automatic block_read(input int n, output logic nak_any);
        logic k;
        nak_any = 0;
        bus_start();
        send_byte(8'hD2, k); nak_any |= k;
        send_byte(8'h00, k); nak_any |= k;
        bus_start();
        send_byte(8'hD3, k); nak_any |= k;
        for (int i = 0; i <= n; i++) recv_byte(i == n, rbuf[i]);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic nk;
        mdl[0] = 8'h40; mdl[1] = 8'h7F; mdl[2] = 8'h00; mdl[3] = 8'hFF;
        mdl[4] = 8'h47; mdl[5] = 8'hDF; mdl[6] = 8'h03;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        chk(cfg == exp_cfg(), "R1 reset cfg", cfg, exp_cfg());
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

        // R1, R4, R7, R8: defaults read back over the bus
        for (int off = 0; off < 8; off++) begin
            byte_read(7'(off), v, nk);
            chk(!nk, "R4 read acks", nk, 0);
            chk(v == exp_rd(off), "R1 R4 default readback", v, exp_rd(off));
        end

        // R3, R4, R8: two patterns at every offset
        for (int p = 0; p < 2; p++) begin
            for (int off = 0; off < 8; off++) begin
                logic [7:0] pat;
                pat = 8'(8'h5A + off * 37);
                if (p == 1) pat = ~pat;
                byte_write(7'(off), pat, nk);
                mdl_write(off, pat);
                chk(!nk, "R3 write acks", nk, 0);
                chk(cfg == exp_cfg(), "R3 R8 cfg after byte write", cfg, exp_cfg());
                byte_read(7'(off), v, nk);
                chk(v == exp_rd(off), "R4 R8 readback", v, exp_rd(off));
            end
        end

        // R9: high offsets
        for (int k = 0; k < 3; k++) begin
            logic [6:0] off;
            off = (k == 0) ? 7'd8 : (k == 1) ? 7'h40 : 7'h7F;
            byte_write(off, 8'hC3, nk);
            chk(cfg == exp_cfg(), "R9 high write ignored", cfg, exp_cfg());
            byte_read(off, v, nk);
            chk(v == 8'h00, "R9 high read zero", v, 0);
        end

        // R2: foreign addresses
        for (int k = 0; k < 2; k++) begin
            logic n;
            bus_start();
            send_byte(k == 0 ? 8'hD4 : 8'h52, n);
            chk(n == 1'b1, "R2 foreign address no ack", n, 1);
            send_byte(8'h81, n);
            send_byte(8'h00, n);
            bus_stop();
            chk(cfg == exp_cfg(), "R2 foreign address no effect", cfg, exp_cfg());
        end

        // R7: status sweep
        for (int s = 0; s < 32; s++) begin
            logic [7:0] r3;
            strap = 2'(s);
            cpu_n = s[2];
            pci_n = s[3];
            r3 = {s[4], mdl[3][6:0]};
            byte_write(7'd3, r3, nk);
            mdl_write(3, r3);
            byte_read(7'd0, v, nk);
            chk(v == exp_rd(0), "R7 offset0 status", v, exp_rd(0));
        end

        // R5: partial and full block writes
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h11 * (i + 1));
        block_write(3, nk);
        for (int i = 0; i < 3; i++) mdl_write(i, wbuf[i]);
        chk(!nk, "R5 block write acks", nk, 0);
        chk(cfg == exp_cfg(), "R5 partial block write", cfg, exp_cfg());
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hE7 - 8'(i * 29));
        block_write(8, nk);
        for (int i = 0; i < 8; i++) mdl_write(i, wbuf[i]);
        chk(cfg == exp_cfg(), "R5 full block write", cfg, exp_cfg());

        // R6: full and partial block reads
        block_read(8, nk);
        chk(!nk, "R6 block read acks", nk, 0);
        chk(rbuf[0] == 8'h08, "R6 block count", rbuf[0], 8);
        for (int i = 0; i < 8; i++)
            chk(rbuf[i+1] == exp_rd(i), "R6 block data", rbuf[i+1], exp_rd(i));
        block_read(3, nk);
        chk(rbuf[0] == 8'h08, "R6 partial block count", rbuf[0], 8);
        for (int i = 0; i < 3; i++)
            chk(rbuf[i+1] == exp_rd(i), "R6 partial block data", rbuf[i+1], exp_rd(i));
        byte_read(7'd5, v, nk);
        chk(v == exp_rd(5), "R6 byte read after NACK end", v, exp_rd(5));
        chk(sda_oe == 1'b0, "R10 released when idle", sda_oe, 0);

        finish_run();
    end

endmodule